// File: doc/BRIEF.md
# Blit Read-Back FIFO Controller

This block is the host-facing half of a 2D block-transfer engine for read-type transfers. The host sets a width field (the pixel width minus one), a destination phase, a row count, a row-to-row offset in 16-bit words and a source base address. It then writes a control byte with bit 7 set. The engine works out how many 16-bit words the transfer produces. It walks the source memory row by row and pushes each fetched word into a 16-entry FIFO, which the host empties through a pop port.

The host reads a status byte. It tells the host whether a transfer is still in progress and how full the FIFO is, so the host knows how many words it may read in one burst. Fetches pause while the FIFO has no room and continue when the host pops. Rows can follow the programmed offset (rectangular mode) or run back to back (linear mode).

The source is a synchronous word memory with one cycle of read latency. A typical use is reading back a screen region: with a 640-byte stride the offset is 320 words.

Top module: `blit_readback_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, and `popData` reads 0 while `popEn` is low or high.
- R2: A control write with bit 7 set while idle makes status bit 7 (active) read 1 from the next cycle on.
- R3: A transfer yields exactly ((widthField + 1 + phase) / 2) × rows words, using integer division; for example, field 99, phase 0 and 20 rows give 1000 words. A zero-word transfer drops active within two cycles.
- R4: With control bit 0 clear (rectangular), word c of row r equals memory[base + r × offset + c].
- R5: With control bit 0 set (linear), word k equals memory[base + k].
- R6: A control write with bit 7 set while active is ignored, and the running transfer's word stream is unchanged.
- R7: The status flags are: bit 4 when occupancy ≥ 1, bit 5 when occupancy ≥ 8, and bit 6 when occupancy = 16.
- R8: The FIFO never holds more than 16 words. When the host stops popping, fetches stall, and no word is lost or repeated.
- R9: A pop of an empty FIFO returns 0 and does not disturb the FIFO contents.
- R10: Active stays 1 until every word has been pushed and the host has drained the FIFO. It then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWidth | input | WW | Width field (pixel width minus one) |
| cfgHeight | input | HW | Number of rows |
| cfgPhase | input | 1 | Destination phase |
| cfgOffset | input | AW | Row-to-row offset in words |
| cfgSrcBase | input | AW | Source start word address |
| ctrlWrEn | input | 1 | Control byte write strobe |
| ctrlWrData | input | 8 | Control byte: bit 7 start, bit 0 linear |
| statusOut | output | 8 | Bit 7 active, bit 6 full, bit 5 half full, bit 4 not empty |
| popEn | input | 1 | Host pop strobe |
| popData | output | DW | Head word (0 when empty) |
| memRdEn | output | 1 | Source read request |
| memAddr | output | AW | Source word address |
| memRdData | input | DW | Source data, one cycle after request |

## Verification
The bench leaves the FIFO alone long enough for it to fill, then checks each flag boundary. A wrong stall would overflow the FIFO and corrupt or drop words, and a wrong threshold would misreport how many words a burst may take. It fires a second start in the middle of a transfer; a design that accepted it would restart the address walk, and the word sequence would break. It also covers a zero-word transfer, a pop of an empty FIFO at idle, and the rectangular and linear walks under random pop gaps. A wrong word count, a wrong row jump or an early drop of active shows up as missing, extra or wrong words.

// File: rtl/blit_pkg.sv
package blit_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;    // latch configuration, reset address walk
    logic issue;   // issue one source read this cycle
    logic rowEnd;  // this read is the last of its row
  } blitStrobe_t;
endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int WW = 10,
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic [WW-1:0] cfgWidth,
  input  logic          cfgPhase,
  input  logic [HW-1:0] cfgHeight,
  input  logic          room,
  input  logic          pending,
  input  logic          fifoEmpty,
  output logic          active,
  output blitStrobe_t   strobe
);
  logic [WW:0]   sumWords;
  logic [WW-1:0] rowWords, rowWordsLat, colCnt;
  logic [HW-1:0] rowsLat, rowCnt;
  logic          issuing, start, issue, lastCol;

  assign sumWords = ({1'b0, cfgWidth} + (WW+1)'(1) + (WW+1)'(cfgPhase)) >> 1;
  assign rowWords = sumWords[WW-1:0];
  assign start    = startReq & ~active;
  assign issue    = issuing & room;
  assign lastCol  = (colCnt == rowWordsLat - WW'(1));

  assign strobe.load   = start;
  assign strobe.issue  = issue;
  assign strobe.rowEnd = issue & lastCol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active      <= 1'b0;
      issuing     <= 1'b0;
      rowWordsLat <= '0;
      rowsLat     <= '0;
      colCnt      <= '0;
      rowCnt      <= '0;
    end else if (start) begin
      active      <= 1'b1;
      rowWordsLat <= rowWords;
      rowsLat     <= cfgHeight;
      colCnt      <= '0;
      rowCnt      <= '0;
      issuing     <= (rowWords != '0) && (cfgHeight != '0);
    end else begin
      if (issue) begin
        if (lastCol) begin
          colCnt <= '0;
          if (rowCnt == rowsLat - HW'(1)) issuing <= 1'b0;
          else                            rowCnt  <= rowCnt + HW'(1);
        end else begin
          colCnt <= colCnt + WW'(1);
        end
      end
      if (active && !issuing && !pending && fifoEmpty) active <= 1'b0;
    end
  end
endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  blitStrobe_t   strobe,
  input  logic [AW-1:0] cfgSrcBase,
  input  logic [AW-1:0] cfgOffset,
  input  logic          linSel,
  input  logic [DW-1:0] memRdData,
  input  logic          popEn,
  output logic          memRdEn,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] popData,
  output logic          room,
  output logic          pending,
  output logic [CW-1:0] fifoCount,
  output logic          notEmpty,
  output logic          halfFull,
  output logic          full
);
  logic [AW-1:0] addr, rowBase, offLat;
  logic          linLat;
  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic          push, pop;

  assign memRdEn  = strobe.issue;
  assign memAddr  = addr;
  assign push     = pending;
  assign pop      = popEn && (fifoCount != '0);
  assign room     = ((CW+1)'(fifoCount) + (CW+1)'(pending)) < (CW+1)'(DEPTH);
  assign notEmpty = (fifoCount != '0);
  assign halfFull = (fifoCount >= CW'(DEPTH / 2));
  assign full     = (fifoCount == CW'(DEPTH));
  assign popData  = notEmpty ? store[rdPtr] : '0;

  // address walk
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr    <= '0;
      rowBase <= '0;
      offLat  <= '0;
      linLat  <= 1'b0;
      pending <= 1'b0;
    end else begin
      pending <= strobe.issue;
      if (strobe.load) begin
        addr    <= cfgSrcBase;
        rowBase <= cfgSrcBase;
        offLat  <= cfgOffset;
        linLat  <= linSel;
      end else if (strobe.issue) begin
        if (strobe.rowEnd && !linLat) begin
          addr    <= rowBase + offLat;
          rowBase <= rowBase + offLat;
        end else begin
          addr <= addr + AW'(1);
        end
      end
    end
  end

  // FIFO storage
  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= memRdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + PW'(1);
      if (pop)  rdPtr <= rdPtr + PW'(1);
      fifoCount <= fifoCount + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/blit_readback_ctrl.sv
module blit_readback_ctrl
  import blit_pkg::*;
#(
  parameter int WW    = 10,
  parameter int HW    = 10,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [WW-1:0] cfgWidth,
  input  logic [HW-1:0] cfgHeight,
  input  logic          cfgPhase,
  input  logic [AW-1:0] cfgOffset,
  input  logic [AW-1:0] cfgSrcBase,
  input  logic          ctrlWrEn,
  input  logic [7:0]    ctrlWrData,
  output logic [7:0]    statusOut,
  input  logic          popEn,
  output logic [DW-1:0] popData,
  output logic          memRdEn,
  output logic [AW-1:0] memAddr,
  input  logic [DW-1:0] memRdData
);
  blitStrobe_t   strobe;
  logic          active, room, pending, notEmpty, halfFull, full;
  logic [CW-1:0] fifoCount;
  logic          unusedCtrlBits;

  assign unusedCtrlBits = ^ctrlWrData[6:1];
  assign statusOut = {active, full, halfFull, notEmpty, 4'b0000};

  blit_ctrl #(.WW(WW), .HW(HW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReq(ctrlWrEn & ctrlWrData[7]),
    .cfgWidth(cfgWidth), .cfgPhase(cfgPhase), .cfgHeight(cfgHeight),
    .room(room), .pending(pending), .fifoEmpty(!notEmpty),
    .active(active), .strobe(strobe)
  );

  blit_datapath #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgSrcBase(cfgSrcBase), .cfgOffset(cfgOffset), .linSel(ctrlWrData[0]),
    .memRdData(memRdData), .popEn(popEn),
    .memRdEn(memRdEn), .memAddr(memAddr), .popData(popData),
    .room(room), .pending(pending), .fifoCount(fifoCount),
    .notEmpty(notEmpty), .halfFull(halfFull), .full(full)
  );
endmodule

// File: rtl/blit_readback_chk.sv
module blit_readback_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          ctrlWrEn,
  input logic [7:0]    ctrlWrData,
  input logic [7:0]    statusOut,
  input logic          popEn,
  input logic [DW-1:0] popData,
  input logic          memRdEn,
  input logic [CW-1:0] fifoCount
);
  p_start_sets_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && ctrlWrData[7] && !statusOut[7]) |=> statusOut[7]);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CW'(DEPTH));

  p_flag_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[6] |-> (statusOut[5] && statusOut[4]));

  p_empty_read_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !statusOut[4]) |-> (popData == '0));

  p_active_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[7] && statusOut[4]) |=> statusOut[7]);

  p_fetch_only_active_r8: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> statusOut[7]);
endmodule

bind blit_readback_ctrl blit_readback_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
  .statusOut(statusOut), .popEn(popEn), .popData(popData),
  .memRdEn(memRdEn), .fifoCount(fifoCount)
);

// File: tb/blit_readback_ctrl_bench.sv
module blit_readback_ctrl_bench;
  logic        clk = 0;
  logic        rstN = 0;
  logic [9:0]  cfgWidth = 0;
  logic [9:0]  cfgHeight = 0;
  logic        cfgPhase = 0;
  logic [15:0] cfgOffset = 0, cfgSrcBase = 0;
  logic        ctrlWrEn = 0;
  logic [7:0]  ctrlWrData = 0;
  logic [7:0]  statusOut;
  logic        popEn = 0;
  logic [15:0] popData, memAddr, memRdData;
  logic        memRdEn;

  int checks = 0, errors = 0;
  int eBase, eOff, eRw, eLin;

  always #10 clk = ~clk;  // 50 MHz

  blit_readback_ctrl u_blit_readback_ctrl (
    .clk(clk), .rstN(rstN), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .cfgPhase(cfgPhase), .cfgOffset(cfgOffset), .cfgSrcBase(cfgSrcBase),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .statusOut(statusOut),
    .popEn(popEn), .popData(popData), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData)
  );

  function automatic logic [15:0] pat(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] expWord(input int k);
    int r = k / eRw;
    int c = k % eRw;
    logic [15:0] a;
    if (eLin != 0) a = 16'(eBase + k);
    else           a = 16'(eBase + r * eOff + c);
    return pat(a);
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= pat(memAddr);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic startBlit(input int wf, input int ph, input int ht,
                           input int off, input int base, input int lin);
    cfgWidth = 10'(wf); cfgPhase = ph[0]; cfgHeight = 10'(ht);
    cfgOffset = 16'(off); cfgSrcBase = 16'(base);
    eBase = base; eOff = off; eRw = (wf + 1 + ph) / 2; eLin = lin;
    ctrlWrEn = 1; ctrlWrData = 8'h80 | 8'(lin);
    @(negedge clk);
    ctrlWrEn = 0; ctrlWrData = 0;
  endtask

  // pop until active drops; first expected index k0
  task automatic drain(input int k0, input int total, input int gapMax,
                       input bit inject, input string req);
    int got = k0;
    int cyc = 0;
    bit injected = 0;
    while (statusOut[7] && cyc < 20000) begin
      cyc++;
      if (inject && !injected && got == k0 + 2) begin
        injected = 1;
        ctrlWrEn = 1; ctrlWrData = 8'h81;
        cfgSrcBase = 16'(eBase + 1000); cfgWidth = 10'd3; cfgHeight = 10'd1;
      end
      if (statusOut[4] && ($urandom % (gapMax + 1)) == 0) begin
        popEn = 1;
        if (got < total)
          chk(popData == expWord(got), req, $sformatf("word %0d", got),
              popData, expWord(got));
        got++;
      end
      @(negedge clk);
      popEn = 0; ctrlWrEn = 0; ctrlWrData = 0;
    end
    chk(got == total, "R3", "word count", got, total);
    chk(statusOut == 8'h00, "R10", "status after drain", statusOut, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(statusOut == 8'h00, "R1", "reset status", statusOut, 0);
    chk(popData == 16'h0, "R1", "reset popData", popData, 0);
    rstN = 1;
    @(negedge clk);

    // R9: empty pop at idle returns 0 and disturbs nothing
    popEn = 1;
    chk(popData == 16'h0, "R9", "empty pop data", popData, 0);
    @(negedge clk);
    popEn = 0;
    chk(statusOut == 8'h00, "R9", "status after empty pop", statusOut, 0);

    // R7/R10: 10-word transfer, host waits
    startBlit(19, 0, 1, 0, 16'h0200, 0);
    chk(statusOut[7] == 1, "R2", "active after start", statusOut[7], 1);
    repeat (30) @(negedge clk);
    chk(statusOut[7:4] == 4'b1011, "R7", "flags at 10 words", statusOut[7:4], 4'b1011);
    for (int i = 0; i < 3; i++) begin
      popEn = 1;
      chk(popData == expWord(i), "R9", "word after empty pop", popData, expWord(i));
      @(negedge clk);
      popEn = 0;
    end
    chk(statusOut[7:4] == 4'b1001, "R7", "flags at 7 words", statusOut[7:4], 4'b1001);
    chk(statusOut[7] == 1, "R10", "active with words left", statusOut[7], 1);
    drain(3, 10, 0, 0, "R4");

    // R7/R8: 32-word transfer fills the FIFO and stalls
    startBlit(63, 0, 1, 0, 16'h1000, 0);
    repeat (40) @(negedge clk);
    chk(statusOut[7:4] == 4'b1111, "R7", "flags when full", statusOut[7:4], 4'b1111);
    drain(0, 32, 0, 0, "R8");

    // R3: zero-word transfer
    startBlit(0, 0, 5, 4, 16'h0300, 0);
    repeat (2) @(negedge clk);
    chk(statusOut == 8'h00, "R3", "zero-word ends", statusOut, 0);

    // R3/R4: 100-wide, 20 rows, 640-byte stride
    startBlit(99, 0, 20, 320, 16'h4000, 0);
    drain(0, 1000, 0, 0, "R4");

    // R6: second start mid-transfer is ignored
    startBlit(29, 1, 3, 40, 16'h0500, 0);
    drain(0, 45, 2, 1, "R6");

    // R5: linear
    startBlit(20, 1, 4, 999, 16'h0700, 1);
    drain(0, 44, 1, 0, "R5");

    // random mix, R4/R5/R8
    for (int n = 0; n < 20; n++) begin
      int wf = $urandom % 41;
      int ph = $urandom % 2;
      int ht = 1 + $urandom % 6;
      int off = $urandom % 200;
      int base = $urandom % 65536;
      int lin = $urandom % 2;
      startBlit(wf, ph, ht, off, base, lin);
      drain(0, ((wf + 1 + ph) / 2) * ht, $urandom % 4, 0, lin ? "R5" : "R4");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule